// File: doc/BRIEF.md
# Coalescing Vector Gather Unit

The unit collects up to eight 32-bit elements from scattered memory locations into one result vector. A request carries a base byte address, eight per-lane 32-bit byte offsets, a lane enable mask and a merge vector. Lanes that are switched off take their element from the merge vector. Each enabled lane reads the word at base plus its offset.

The unit reads whole 64-byte lines through two cache read ports that work in parallel. Each port has a fixed one-cycle latency. Every pending lane that falls into a line being read is served by that single access. The number of access cycles therefore follows the number of distinct lines touched, not the number of lanes.

A controller with four states sequences the work:
- `G_IDLE` accepts a request. It moves to `G_DONE` for an empty mask or a misaligned lane, and to `G_ISSUE` otherwise.
- `G_ISSUE` drives the ports once per cycle. It moves to `G_DRAIN` once no lane is left pending.
- `G_DRAIN` captures the last returned lines and moves to `G_DONE`.
- `G_DONE` pulses completion and returns to `G_IDLE`.

Top module: `vec_gather_unit`

## Requirements
- R1: An enabled lane's result is the 32-bit word at byte address base + offset. That word is taken from the returned line at word index address[5:2], where word k occupies line bits [32k+31:32k].
- R2: All pending lanes that share one 64-byte line are served by a single port access in the same cycle. A gather whose lanes all fall into one line takes exactly one access cycle.
- R3: The two ports run in the same cycle on different lines. Port 0 serves the line of the lowest-numbered pending lane. Port 1 serves the line of the lowest-numbered remaining lane. Port 1 is never active without port 0, so eight lanes on eight lines take four access cycles.
- R4: A lane whose mask bit is 0 issues no access and returns its merge-vector element unchanged.
- R5: A request with an all-zero mask completes in the first cycle after acceptance. It causes no port activity and returns the merge vector.
- R6: If any enabled lane's address is not 4-byte aligned, the request completes in the first cycle after acceptance with the error flag set. There is no port activity and the merge vector is returned. A misaligned address on a disabled lane is not an error.
- R7: After reset, ready is high and done and both port requests are low. Ready falls after acceptance and stays low until the done cycle has passed. A valid request presented while busy is ignored.
- R8: Done is a one-cycle pulse. For a gather that uses n access cycles, it is high in cycle n+2 after the accepting clock edge.
- R9: The cycle count output equals the number of access cycles the last gather used. That is ceil(distinct lines / 2) under the selection order of R3, and 0 for R5 and R6.
- R10: Port addresses are byte addresses of a line, with bits [5:0] zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_base | input | 32 | Base byte address |
| req_offsets | input | 256 | Lane byte offsets, lane i at bits [32i+31:32i] |
| req_mask | input | 8 | Lane enables, bit i for lane i |
| req_merge | input | 256 | Values kept by disabled lanes |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Misaligned lane address seen, valid with done |
| result | output | 256 | Assembled vector, lane i at bits [32i+31:32i] |
| used_cycles | output | 4 | Access cycles used by the last gather |
| p0_req | output | 1 | Port 0 line read request |
| p0_addr | output | 32 | Port 0 line byte address |
| p0_line | input | 512 | Port 0 line data, one cycle after request |
| p1_req | output | 1 | Port 1 line read request |
| p1_addr | output | 32 | Port 1 line byte address |
| p1_line | input | 512 | Port 1 line data, one cycle after request |

## Verification
Line data arrives in the cycle after a port request. The done pulse is due in cycle n+2 after the accepting edge for n access cycles, and in cycle 1 for an empty mask or a misaligned lane. The bench counts cycles from the accepting edge, samples on falling edges, and checks done in exactly that cycle. It then checks that done has dropped one cycle later. Port requests are sampled on falling edges and counted against the expected n. The result, error flag and cycle count are read together with the done pulse.

// File: rtl/gather_pkg.sv
package gather_pkg;
    typedef enum logic [1:0] {
        G_IDLE,
        G_ISSUE,
        G_DRAIN,
        G_DONE
    } gstate_t;
endpackage

// File: rtl/gather_line_pick.sv
module gather_line_pick #(
    parameter int LANES = 8,
    parameter int TAG_W = 26
) (
    input  logic [LANES-1:0]            pend,
    input  logic [LANES-1:0][TAG_W-1:0] tags,
    output logic                        found,
    output logic [TAG_W-1:0]            tag,
    output logic [LANES-1:0]            grp
);
    // lowest pending lane picks the line; every pending lane on it joins
    always_comb begin
        found = |pend;
        tag   = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend[i]) tag = tags[i];
        end
        for (int i = 0; i < LANES; i++) begin
            grp[i] = pend[i] && (tags[i] == tag);
        end
    end
endmodule

// File: rtl/gather_word_pick.sv
module gather_word_pick #(
    parameter int LINE_W = 512,
    parameter int DW     = 32,
    parameter int WSEL_W = 4
) (
    input  logic [LINE_W-1:0] line,
    input  logic [WSEL_W-1:0] wsel,
    output logic [DW-1:0]     word
);
    always_comb word = line[wsel*DW +: DW];
endmodule

// File: rtl/vec_gather_unit.sv
module vec_gather_unit
    import gather_pkg::*;
#(
    parameter int LANES      = 8,
    parameter int DW         = 32,
    parameter int AW         = 32,
    parameter int LINE_BYTES = 64,
    localparam int OFS_W     = $clog2(LINE_BYTES),
    localparam int BYTE_LSB  = $clog2(DW / 8),
    localparam int WSEL_W    = OFS_W - BYTE_LSB,
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int TAG_W     = AW - OFS_W,
    localparam int CNT_W     = $clog2(LANES) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [AW-1:0]       req_base,
    input  logic [LANES*AW-1:0] req_offsets,
    input  logic [LANES-1:0]    req_mask,
    input  logic [LANES*DW-1:0] req_merge,
    output logic                done,
    output logic                done_err,
    output logic [LANES*DW-1:0] result,
    output logic [CNT_W-1:0]    used_cycles,
    output logic                p0_req,
    output logic [AW-1:0]       p0_addr,
    input  logic [LINE_W-1:0]   p0_line,
    output logic                p1_req,
    output logic [AW-1:0]       p1_addr,
    input  logic [LINE_W-1:0]   p1_line
);
    localparam logic [CNT_W-1:0] MAX_CYC = CNT_W'((LANES + 1) / 2);

    gstate_t state_q, state_d;

    logic [LANES-1:0][AW-BYTE_LSB-1:0] addr_q;
    logic [LANES-1:0]                  pend_q, sel0_q, sel1_q;
    logic [LANES-1:0][DW-1:0]          res_q;
    logic                              err_q;
    logic [CNT_W-1:0]                  cnt_q;

    logic                              accept, misaligned;
    logic [LANES-1:0][AW-1:0]          new_addr;
    logic [LANES-1:0][TAG_W-1:0]       tags;
    logic [LANES-1:0]                  issue_pend, rest_pend, left_pend;
    logic [LANES-1:0]                  grp0, grp1;
    logic                              found0, found1;
    logic [TAG_W-1:0]                  tag0, tag1;
    logic [LANES-1:0][DW-1:0]          ext0, ext1;

    assign accept = req_valid && req_ready;

    always_comb begin
        misaligned = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            new_addr[i] = req_base + req_offsets[i*AW +: AW];
            if (req_mask[i] && (new_addr[i][BYTE_LSB-1:0] != '0)) misaligned = 1'b1;
        end
    end

    assign issue_pend = (state_q == G_ISSUE) ? pend_q : '0;
    assign rest_pend  = issue_pend & ~grp0;
    assign left_pend  = rest_pend & ~grp1;

    gather_line_pick #(.LANES(LANES), .TAG_W(TAG_W)) u_pick0 (
        .pend(issue_pend), .tags(tags), .found(found0), .tag(tag0), .grp(grp0)
    );
    gather_line_pick #(.LANES(LANES), .TAG_W(TAG_W)) u_pick1 (
        .pend(rest_pend), .tags(tags), .found(found1), .tag(tag1), .grp(grp1)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign tags[g] = addr_q[g][AW-BYTE_LSB-1:WSEL_W];
        gather_word_pick #(.LINE_W(LINE_W), .DW(DW), .WSEL_W(WSEL_W)) u_w0 (
            .line(p0_line), .wsel(addr_q[g][WSEL_W-1:0]), .word(ext0[g])
        );
        gather_word_pick #(.LINE_W(LINE_W), .DW(DW), .WSEL_W(WSEL_W)) u_w1 (
            .line(p1_line), .wsel(addr_q[g][WSEL_W-1:0]), .word(ext1[g])
        );
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= G_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            G_IDLE:  if (accept) state_d = (misaligned || req_mask == '0) ? G_DONE : G_ISSUE;
            G_ISSUE: if (left_pend == '0) state_d = G_DRAIN;
            G_DRAIN: state_d = G_DONE;
            G_DONE:  state_d = G_IDLE;
            default: state_d = G_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready   = (state_q == G_IDLE);
        done        = (state_q == G_DONE);
        done_err    = err_q;
        result      = res_q;
        used_cycles = cnt_q;
        p0_req      = found0;
        p0_addr     = {tag0, {OFS_W{1'b0}}};
        p1_req      = found1;
        p1_addr     = {tag1, {OFS_W{1'b0}}};
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            pend_q <= '0;
            sel0_q <= '0;
            sel1_q <= '0;
            res_q  <= '0;
            err_q  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            sel0_q <= grp0;
            sel1_q <= grp1;
            if (accept) begin
                for (int i = 0; i < LANES; i++) begin
                    addr_q[i] <= new_addr[i][AW-1:BYTE_LSB];
                    res_q[i]  <= req_merge[i*DW +: DW];
                end
                pend_q <= misaligned ? '0 : req_mask;
                err_q  <= misaligned;
                cnt_q  <= '0;
            end else begin
                if (state_q == G_ISSUE) begin
                    pend_q <= left_pend;
                    cnt_q  <= cnt_q + 1'b1;
                end
                for (int i = 0; i < LANES; i++) begin
                    if (sel0_q[i])      res_q[i] <= ext0[i];
                    else if (sel1_q[i]) res_q[i] <= ext1[i];
                end
            end
        end
    end

    a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r3_ports_split: assert property (@(posedge clk) disable iff (!rst_n)
        p1_req |-> (p0_req && p1_addr != p0_addr));
    a_r3_cycle_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> used_cycles <= MAX_CYC);
    a_r6_err_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_err) |-> used_cycles == '0);
    a_r7_no_port_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !p0_req);
endmodule

// File: tb/tb_vec_gather_unit.sv
`timescale 1ns/1ps
module tb_vec_gather_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_base = '0;
    logic [255:0] req_offsets = '0;
    logic [7:0]   req_mask = '0;
    logic [255:0] req_merge = '0;
    logic         done, done_err;
    logic [255:0] result;
    logic [3:0]   used_cycles;
    logic         p0_req, p1_req;
    logic [31:0]  p0_addr, p1_addr;
    logic [511:0] p0_line = '0, p1_line = '0;

    vec_gather_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_base(req_base), .req_offsets(req_offsets), .req_mask(req_mask),
        .req_merge(req_merge), .done(done), .done_err(done_err), .result(result),
        .used_cycles(used_cycles), .p0_req(p0_req), .p0_addr(p0_addr), .p0_line(p0_line),
        .p1_req(p1_req), .p1_addr(p1_addr), .p1_line(p1_line)
    );

    int n_checks = 0;
    int n_fail = 0;
    int port_total = 0;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return a * 32'h9E3779B1 + 32'h55;
    endfunction

    function automatic logic [511:0] build_line(input logic [31:0] la);
        logic [511:0] l;
        for (int k = 0; k < 16; k++) l[k*32 +: 32] = mem_word(la + 32'(k * 4));
        return l;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // cache model: requests sampled on falling edge, line returned one cycle later
    logic        s0, s1;
    logic [31:0] sa0, sa1;
    always @(negedge clk) begin
        s0 = p0_req; s1 = p1_req; sa0 = p0_addr; sa1 = p1_addr;
        if (p0_req || p1_req) begin
            port_total++;
            check(p0_addr[5:0] == 0 && (!p1_req || p1_addr[5:0] == 0), "R10",
                  "line address alignment", {p1_addr, p0_addr}, '0);
            check(!p1_req || (p0_req && p1_addr != p0_addr), "R3",
                  "ports on distinct lines", {p1_addr, p0_addr}, '0);
        end
    end
    always @(posedge clk) begin
        if (s0) p0_line <= build_line(sa0);
        if (s1) p1_line <= build_line(sa1);
    end

    localparam int NT = 5;
    localparam logic [31:0]  T_BASE [NT] = '{32'h1000, 32'h4000, 32'h1000, 32'h8000, 32'h2020};
    localparam logic [255:0] T_OFF  [NT] = '{
        {32'h1c, 32'h18, 32'h14, 32'h10, 32'h0c, 32'h08, 32'h04, 32'h00},
        {32'h1c0, 32'h180, 32'h140, 32'h100, 32'hc0, 32'h80, 32'h40, 32'h00},
        {32'h4c, 32'h0c, 32'h48, 32'h08, 32'h44, 32'h04, 32'h40, 32'h00},
        {32'h380, 32'h300, 32'h280, 32'h200, 32'h180, 32'h100, 32'h80, 32'h00},
        {32'h204, 32'h200, 32'h3c, 32'h24, 32'h20, 32'h1c, 32'h04, 32'h00}};
    localparam logic [7:0]   T_MASK [NT] = '{8'hff, 8'hff, 8'hff, 8'h5a, 8'hff};
    localparam int           T_N    [NT] = '{1, 4, 1, 2, 2};

    task automatic run_g(input string tag, input logic [31:0] base, input logic [255:0] offs,
                         input logic [7:0] mask, input bit hold, input bit exp_err, input int exp_n);
        logic [255:0] merge, exp_res;
        int k, p_start, exp_k;
        bit busy_ready;
        for (int i = 0; i < 8; i++) begin
            merge[i*32 +: 32] = 32'hDEAD0000 | 32'(i) | (base << 8);
            exp_res[i*32 +: 32] = (mask[i] && !exp_err) ?
                mem_word(base + offs[i*32 +: 32]) : merge[i*32 +: 32];
        end
        exp_k = (exp_err || mask == 0) ? 1 : exp_n + 2;
        @(negedge clk);
        check(req_ready, "R7", {tag, " ready before request"}, 256'(req_ready), 256'(1));
        p_start = port_total;
        req_valid = 1'b1; req_base = base; req_offsets = offs; req_mask = mask; req_merge = merge;
        @(posedge clk);
        k = 0;
        busy_ready = 1'b0;
        do begin
            @(negedge clk);
            k++;
            if (hold) begin
                req_base = 32'h7770_0000; req_mask = 8'hff; req_offsets = '0;
            end else req_valid = 1'b0;
            if (req_ready) busy_ready = 1'b1;
        end while (!done && k < 40);
        req_valid = 1'b0;
        check(k == exp_k, "R8", {tag, " done cycle"}, 256'(k), 256'(exp_k));
        check(!busy_ready, "R7", {tag, " ready low while busy"}, 256'(busy_ready), 256'(0));
        check(result == exp_res, "R1", {tag, " result (R4 merge lanes)"}, result, exp_res);
        check(done_err == exp_err, "R6", {tag, " error flag"}, 256'(done_err), 256'(exp_err));
        check(used_cycles == 4'(exp_n), "R9", {tag, " used cycles"}, 256'(used_cycles), 256'(exp_n));
        check(port_total - p_start == exp_n, "R2", {tag, " port active cycles"},
              256'(port_total - p_start), 256'(exp_n));
        @(negedge clk);
        check(!done && req_ready, "R8", {tag, " done pulse ends"}, 256'({done, req_ready}), 256'(1));
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready && !done && !p0_req && !p1_req, "R7", "reset state",
              256'({req_ready, done, p0_req, p1_req}), 256'(4'b1000));
        rst_n = 1'b1;
        // table walk: R2 single line, R3 scattered, R4 partial mask, R1 unaligned base
        for (int t = 0; t < NT; t++) begin
            run_g($sformatf("table%0d", t), T_BASE[t], T_OFF[t], T_MASK[t], 1'b0, 1'b0, T_N[t]);
        end
        // R5 empty mask
        run_g("R5 empty mask", 32'h3000, T_OFF[1], 8'h00, 1'b0, 1'b0, 0);
        // R6 misaligned enabled lane
        run_g("R6 misaligned", 32'h3000, {T_OFF[0][255:128], 32'h0e, T_OFF[0][95:0]}, 8'hff, 1'b0, 1'b1, 0);
        // R6 misaligned lane disabled: no error
        run_g("R6 masked misalign", 32'h3000, {32'h2, T_OFF[0][223:0]}, 8'h0f, 1'b0, 1'b0, 1);
        // R7 valid held during busy is ignored
        run_g("R7 busy hold", T_BASE[1], T_OFF[1], 8'hff, 1'b1, 1'b0, 4);
        // R3 port 1 serves second line: five lines -> three cycles
        run_g("R3 odd lines", 32'h5000, T_OFF[1], 8'h1f, 1'b0, 1'b0, 3);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule